// File: doc/BRIEF.md
# Host packet buffer access controller

This block gives a host processor register-level access to the packet buffer of one asynchronous or control channel. The link side deposits received bytes into a byte-addressed buffer and posts the packet length. The host then fetches that length through a status register and drains the bytes one at a time through a data register. In the transmit direction the host writes a length and then the bytes, and the link side reads them back from the same buffer. A single buffer pointer tracks the position in the current packet. It moves one byte per accepted data access, stops at the packet length and raises a done flag there.

A command register starts packets, pauses and resumes transfers, and rewinds the current packet. A rewind issued before the last byte has moved puts the pointer back to the start and discards the latched length, so the host must fetch or write the length again and repeat the data from the first byte. A paused transfer keeps its pointer and its length, and it continues after resume with no length access. No frame-boundary alignment is applied, because this channel type has none.

Top module: `pkt_host_port`

## Requirements
- R1: After reset, a read of the control register (address 0) returns 0. Its read fields are: bit 0 done, bit 1 paused, bit 2 length-valid, bit 3 direction (0 receive, 1 transmit), and bits 15:8 the buffer pointer.
- R2: Writing command code 3'b001 to control bits 2:0 starts a new packet. The direction is taken from bit 3. Pointer, done, paused and length-valid are all cleared.
- R3: In receive, a read of the status register (address 2) returns the posted length. The first such read while length-valid is clear latches it. Each later read of the data register (address 3) returns the byte at the pointer in bits 7:0 and advances the pointer by one.
- R4: In transmit, the first write to the length register (address 1) while length-valid is clear latches the length, and a read of address 1 returns the latched length. Each data-register write stores bits 7:0 at the pointer and advances it, and the link read port returns the stored bytes.
- R5: Done rises when the pointer reaches the latched length. A length of zero raises done as it is latched. Once done is set, data accesses are ignored, the pointer holds and data reads return 0.
- R6: A posted or written length larger than the buffer depth is clamped to the depth.
- R7: Command 3'b010 before done returns the pointer to 0 and clears length-valid. The length must be accessed again, and a new transmit pass overwrites the earlier bytes.
- R8: Command 3'b010 while done is set has no effect until the next start.
- R9: Command 3'b011 pauses and 3'b100 resumes. While paused, data and length accesses are ignored. After resume the transfer continues from the same pointer without a new length access.
- R10: Command codes 3'b000, 3'b101, 3'b110 and 3'b111 change no state.
- R11: Data accesses before the length is latched, or against the current direction, are ignored. A data read in that case returns 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| reg_wr_i | input | 1 | Host register write strobe |
| reg_rd_i | input | 1 | Host register read strobe |
| reg_addr_i | input | 2 | Host register address |
| reg_wdata_i | input | 16 | Host write data |
| reg_rdata_o | output | 16 | Host read data for the addressed register |
| lnk_we_i | input | 1 | Link byte write into the buffer |
| lnk_addr_i | input | ADDR_W | Link write address |
| lnk_wdata_i | input | 8 | Link write byte |
| lnk_post_i | input | 1 | Link posts a received packet length |
| lnk_len_i | input | 16 | Posted length |
| lnk_raddr_i | input | ADDR_W | Link read address |
| lnk_rdata_o | output | 8 | Buffer byte at the link read address |
| done_o | output | 1 | Current packet fully transferred |
| tx_len_o | output | 16 | Latched length of the current packet |

## Verification
The bench sweeps every length from zero past the buffer depth in both directions. A wrong clamp would move too many bytes, and an off-by-one end check would raise done one byte early or late. It rewinds at every position inside a packet in both directions. A design that kept the old length would let data move with no length access, and one that failed to rewind the write pointer would leave stale bytes visible on the link port. It issues a rewind after done, accesses made while paused, the spare command codes and accesses against the current direction. A design that obeyed any of these would show a moved pointer or a changed flag in the control register.

// File: rtl/pkt_host_port_pkg.sv
package pkt_host_port_pkg;

  localparam logic [2:0] CMD_START  = 3'b001;
  localparam logic [2:0] CMD_REWIND = 3'b010;
  localparam logic [2:0] CMD_PAUSE  = 3'b011;
  localparam logic [2:0] CMD_RESUME = 3'b100;

  localparam logic [1:0] REG_CTRL = 2'd0;
  localparam logic [1:0] REG_LEN  = 2'd1;
  localparam logic [1:0] REG_STAT = 2'd2;
  localparam logic [1:0] REG_DATA = 2'd3;

  localparam int DIR_BIT = 3;

  typedef struct packed {
    logic        start;
    logic        rewind;
    logic        pause;
    logic        resume;
    logic        dir;
    logic        len_wr;
    logic [15:0] len_val;
    logic        stat_rd;
    logic        data_rd;
    logic        data_wr;
    logic [7:0]  data;
  } host_req_t;

  typedef struct packed {
    logic dir;
    logic len_vld;
    logic paused;
    logic done;
  } chan_flags_t;

endpackage

// File: rtl/pkt_host_port_mem.sv
module pkt_host_port_mem #(
  parameter int DEPTH  = 64,
  parameter int ADDR_W = $clog2(DEPTH)
) (
  input  logic              clk_i,
  input  logic              hwe_i,
  input  logic [ADDR_W-1:0] haddr_i,
  input  logic [7:0]        hdata_i,
  input  logic              lwe_i,
  input  logic [ADDR_W-1:0] laddr_i,
  input  logic [7:0]        ldata_i,
  input  logic [ADDR_W-1:0] hraddr_i,
  input  logic [ADDR_W-1:0] lraddr_i,
  output logic [7:0]        hrdata_o,
  output logic [7:0]        lrdata_o
);

  logic [7:0] rows [DEPTH];

  for (genvar r = 0; r < DEPTH; r++) begin : g_row
    logic [7:0] q;
    logic       hsel;
    logic       lsel;
    assign hsel = hwe_i && (haddr_i == ADDR_W'(r));
    assign lsel = lwe_i && (laddr_i == ADDR_W'(r));
    // host write wins a same-cycle collision
    always_ff @(posedge clk_i) begin
      if (hsel)      q <= hdata_i;
      else if (lsel) q <= ldata_i;
    end
    assign rows[r] = q;
  end

  assign hrdata_o = rows[hraddr_i];
  assign lrdata_o = rows[lraddr_i];

endmodule

// File: rtl/pkt_host_port_regif.sv
module pkt_host_port_regif
  import pkt_host_port_pkg::*;
#(
  parameter int PW = 7
) (
  input  logic        wr_i,
  input  logic        rd_i,
  input  logic [1:0]  addr_i,
  input  logic [15:0] wdata_i,
  input  chan_flags_t flags_i,
  input  logic [PW-1:0] ptr_i,
  input  logic [PW-1:0] len_i,
  input  logic [PW-1:0] stage_i,
  input  logic [7:0]  byte_i,
  input  logic        byte_ok_i,
  output host_req_t   req_o,
  output logic [15:0] rdata_o
);

  always_comb begin
    req_o         = '0;
    req_o.dir     = wdata_i[DIR_BIT];
    req_o.len_val = wdata_i;
    req_o.data    = wdata_i[7:0];
    if (wr_i && addr_i == REG_CTRL) begin
      unique case (wdata_i[2:0])
        CMD_START:  req_o.start  = 1'b1;
        CMD_REWIND: req_o.rewind = 1'b1;
        CMD_PAUSE:  req_o.pause  = 1'b1;
        CMD_RESUME: req_o.resume = 1'b1;
        default: ;
      endcase
    end
    req_o.len_wr  = wr_i && addr_i == REG_LEN;
    req_o.stat_rd = rd_i && addr_i == REG_STAT;
    req_o.data_rd = rd_i && addr_i == REG_DATA;
    req_o.data_wr = wr_i && addr_i == REG_DATA;
  end

  always_comb begin
    unique case (addr_i)
      REG_CTRL: rdata_o = {8'(ptr_i), 4'b0000, flags_i.dir, flags_i.len_vld,
                           flags_i.paused, flags_i.done};
      REG_LEN:  rdata_o = 16'(len_i);
      REG_STAT: rdata_o = 16'(stage_i);
      default:  rdata_o = byte_ok_i ? {8'h00, byte_i} : 16'h0000;
    endcase
  end

endmodule

// File: rtl/pkt_host_port_ptr.sv
module pkt_host_port_ptr
  import pkt_host_port_pkg::*;
#(
  parameter int DEPTH = 64,
  parameter int PW    = $clog2(DEPTH + 1)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  host_req_t     req_i,
  input  logic          post_i,
  input  logic [15:0]   post_len_i,
  output logic [PW-1:0] ptr_o,
  output logic [PW-1:0] len_o,
  output logic [PW-1:0] stage_o,
  output chan_flags_t   flags_o,
  output logic          wr_acc_o,
  output logic          byte_ok_o
);

  localparam logic [15:0] DEPTH_W = 16'(DEPTH);

  function automatic logic [PW-1:0] clamp(input logic [15:0] v);
    if (v > DEPTH_W) return PW'(DEPTH);
    return v[PW-1:0];
  endfunction

  logic [PW-1:0] ptr_q, len_q, stage_q, ptr_nxt, len_in;
  logic          dir_q, len_vld_q, paused_q, done_q;
  logic          live, can_rx, can_tx, rd_acc, wr_acc, latch_rx, latch_tx;

  assign live     = !done_q && !paused_q;
  assign can_rx   = live && len_vld_q && !dir_q;
  assign can_tx   = live && len_vld_q && dir_q;
  assign rd_acc   = req_i.data_rd && can_rx;
  assign wr_acc   = req_i.data_wr && can_tx;
  assign latch_rx = req_i.stat_rd && live && !len_vld_q && !dir_q;
  assign latch_tx = req_i.len_wr  && live && !len_vld_q && dir_q;
  assign len_in   = dir_q ? clamp(req_i.len_val) : stage_q;
  assign ptr_nxt  = ptr_q + 1'b1;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) stage_q <= '0;
    else if (post_i) stage_q <= clamp(post_len_i);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ptr_q     <= '0;
      len_q     <= '0;
      dir_q     <= 1'b0;
      len_vld_q <= 1'b0;
      paused_q  <= 1'b0;
      done_q    <= 1'b0;
    end else if (req_i.start) begin
      ptr_q     <= '0;
      len_q     <= '0;
      dir_q     <= req_i.dir;
      len_vld_q <= 1'b0;
      paused_q  <= 1'b0;
      done_q    <= 1'b0;
    end else if (req_i.rewind) begin
      // late rewind is dropped
      if (!done_q) begin
        ptr_q     <= '0;
        len_vld_q <= 1'b0;
      end
    end else begin
      if (req_i.pause)  paused_q <= 1'b1;
      if (req_i.resume) paused_q <= 1'b0;
      if (latch_rx || latch_tx) begin
        len_q     <= len_in;
        len_vld_q <= 1'b1;
        ptr_q     <= '0;
        done_q    <= (len_in == '0);
      end else if (rd_acc || wr_acc) begin
        ptr_q <= ptr_nxt;
        if (ptr_nxt == len_q) done_q <= 1'b1;
      end
    end
  end

  assign ptr_o     = ptr_q;
  assign len_o     = len_q;
  assign stage_o   = stage_q;
  assign flags_o   = '{dir: dir_q, len_vld: len_vld_q, paused: paused_q, done: done_q};
  assign wr_acc_o  = wr_acc;
  assign byte_ok_o = can_rx;

endmodule

// File: rtl/pkt_host_port.sv
module pkt_host_port
  import pkt_host_port_pkg::*;
#(
  parameter int DEPTH  = 64,
  parameter int ADDR_W = $clog2(DEPTH)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              reg_wr_i,
  input  logic              reg_rd_i,
  input  logic [1:0]        reg_addr_i,
  input  logic [15:0]       reg_wdata_i,
  output logic [15:0]       reg_rdata_o,
  input  logic              lnk_we_i,
  input  logic [ADDR_W-1:0] lnk_addr_i,
  input  logic [7:0]        lnk_wdata_i,
  input  logic              lnk_post_i,
  input  logic [15:0]       lnk_len_i,
  input  logic [ADDR_W-1:0] lnk_raddr_i,
  output logic [7:0]        lnk_rdata_o,
  output logic              done_o,
  output logic [15:0]       tx_len_o
);

  localparam int PW = $clog2(DEPTH + 1);

  host_req_t     req;
  chan_flags_t   flags;
  logic [PW-1:0] st_ptr, st_len, stage;
  logic          wr_acc, byte_ok;
  logic [7:0]    hbyte;
  logic          st_len_vld, st_paused, st_done;

  pkt_host_port_regif #(.PW(PW)) u_regif (
    .wr_i     (reg_wr_i),
    .rd_i     (reg_rd_i),
    .addr_i   (reg_addr_i),
    .wdata_i  (reg_wdata_i),
    .flags_i  (flags),
    .ptr_i    (st_ptr),
    .len_i    (st_len),
    .stage_i  (stage),
    .byte_i   (hbyte),
    .byte_ok_i(byte_ok),
    .req_o    (req),
    .rdata_o  (reg_rdata_o)
  );

  pkt_host_port_ptr #(.DEPTH(DEPTH), .PW(PW)) u_ptr (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .req_i     (req),
    .post_i    (lnk_post_i),
    .post_len_i(lnk_len_i),
    .ptr_o     (st_ptr),
    .len_o     (st_len),
    .stage_o   (stage),
    .flags_o   (flags),
    .wr_acc_o  (wr_acc),
    .byte_ok_o (byte_ok)
  );

  pkt_host_port_mem #(.DEPTH(DEPTH), .ADDR_W(ADDR_W)) u_mem (
    .clk_i   (clk_i),
    .hwe_i   (wr_acc),
    .haddr_i (st_ptr[ADDR_W-1:0]),
    .hdata_i (req.data),
    .lwe_i   (lnk_we_i),
    .laddr_i (lnk_addr_i),
    .ldata_i (lnk_wdata_i),
    .hraddr_i(st_ptr[ADDR_W-1:0]),
    .lraddr_i(lnk_raddr_i),
    .hrdata_o(hbyte),
    .lrdata_o(lnk_rdata_o)
  );

  assign st_len_vld = flags.len_vld;
  assign st_paused  = flags.paused;
  assign st_done    = flags.done;
  assign done_o     = st_done;
  assign tx_len_o   = 16'(st_len);

endmodule

// File: rtl/pkt_host_port_chk.sv
module pkt_host_port_chk #(
  parameter int PW = 7
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          wr_i,
  input logic [1:0]    addr_i,
  input logic [2:0]    cmd_i,
  input logic [PW-1:0] ptr_i,
  input logic [PW-1:0] len_i,
  input logic          len_vld_i,
  input logic          paused_i,
  input logic          done_i
);

  logic ctrl_wr, rew, start, spare;
  assign ctrl_wr = wr_i && addr_i == 2'd0;
  assign rew     = ctrl_wr && cmd_i == 3'b010;
  assign start   = ctrl_wr && cmd_i == 3'b001;
  assign spare   = ctrl_wr && cmd_i inside {3'b000, 3'b101, 3'b110, 3'b111};

  // R5
  ptr_bound_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    len_vld_i |-> ptr_i <= len_i);

  // R5
  done_at_len_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_i && len_vld_i |-> ptr_i == len_i);

  // R5
  done_sticky_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_i && !start |=> done_i);

  // R3
  ptr_step_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(ptr_i) |-> (ptr_i == $past(ptr_i) + 1'b1) || (ptr_i == '0));

  // R7
  rewind_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rew && !done_i |=> ptr_i == '0 && !len_vld_i);

  // R8
  late_rewind_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rew && done_i |=> done_i && $stable(ptr_i));

  // R9
  pause_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    paused_i && !ctrl_wr |=> paused_i && $stable(ptr_i) && $stable(len_vld_i));

  // R10
  spare_cmd_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    spare |=> $stable(ptr_i) && $stable(len_vld_i) && $stable(paused_i) && $stable(done_i));

endmodule

bind pkt_host_port pkt_host_port_chk #(.PW(PW)) u_chk (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .wr_i     (reg_wr_i),
  .addr_i   (reg_addr_i),
  .cmd_i    (reg_wdata_i[2:0]),
  .ptr_i    (st_ptr),
  .len_i    (st_len),
  .len_vld_i(st_len_vld),
  .paused_i (st_paused),
  .done_i   (st_done)
);

// File: tb/pkt_host_port_tb_top.sv
module pkt_host_port_tb_top;

  localparam int DEPTH = 16;
  localparam int AW    = 4;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_wr = 1'b0, reg_rd = 1'b0;
  logic [1:0]  reg_addr = '0;
  logic [15:0] reg_wdata = '0, reg_rdata;
  logic        lnk_we = 1'b0, lnk_post = 1'b0;
  logic [AW-1:0] lnk_addr = '0, lnk_raddr = '0;
  logic [7:0]  lnk_wdata = '0, lnk_rdata;
  logic [15:0] lnk_len = '0, tx_len;
  logic        done;

  int n_chk = 0, n_fail = 0;
  bit finished = 0;

  always #5 clk = ~clk;

  pkt_host_port #(.DEPTH(DEPTH), .ADDR_W(AW)) dut_i (
    .clk_i(clk), .rst_ni(rst_n),
    .reg_wr_i(reg_wr), .reg_rd_i(reg_rd), .reg_addr_i(reg_addr),
    .reg_wdata_i(reg_wdata), .reg_rdata_o(reg_rdata),
    .lnk_we_i(lnk_we), .lnk_addr_i(lnk_addr), .lnk_wdata_i(lnk_wdata),
    .lnk_post_i(lnk_post), .lnk_len_i(lnk_len),
    .lnk_raddr_i(lnk_raddr), .lnk_rdata_o(lnk_rdata),
    .done_o(done), .tx_len_o(tx_len)
  );

  function automatic logic [7:0] pat(input int i, input int s);
    return 8'((i * 37 + s * 11 + 5) & 255);
  endfunction

  function automatic int stv(input int p, input int d, input int lv, input int pa, input int dn);
    return (p << 8) | (d << 3) | (lv << 2) | (pa << 1) | dn;
  endfunction

  function automatic int clampl(input int l);
    return (l > DEPTH) ? DEPTH : l;
  endfunction

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic hrd(input logic [1:0] a, output int v);
    @(negedge clk);
    reg_rd = 1'b1; reg_addr = a;
    #1 v = int'(reg_rdata);
    @(posedge clk); #1 reg_rd = 1'b0;
  endtask

  task automatic hwr(input logic [1:0] a, input int d);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = 16'(d);
    @(posedge clk); #1 reg_wr = 1'b0;
  endtask

  task automatic hcmd(input int code, input int dir);
    hwr(2'd0, (dir << 3) | code);
  endtask

  task automatic chk_st(input string req, input int exp);
    int v;
    hrd(2'd0, v);
    chk(req, v, exp);
  endtask

  task automatic lnk_fill(input int seed);
    for (int i = 0; i < DEPTH; i++) begin
      @(negedge clk);
      lnk_we = 1'b1; lnk_addr = AW'(i); lnk_wdata = pat(i, seed);
      @(posedge clk); #1 lnk_we = 1'b0;
    end
  endtask

  task automatic lnk_postlen(input int l);
    @(negedge clk);
    lnk_post = 1'b1; lnk_len = 16'(l);
    @(posedge clk); #1 lnk_post = 1'b0;
  endtask

  task automatic lnk_check(input string req, input int n, input int seed);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      lnk_raddr = AW'(i);
      #1 chk(req, int'(lnk_rdata), int'(pat(i, seed)));
    end
  endtask

  task automatic rx_open(input int l, input int seed);
    hcmd(1, 0);
    lnk_fill(seed);
    lnk_postlen(l);
  endtask

  task automatic rx_bytes(input string req, input int from, input int to, input int seed);
    int v;
    for (int i = from; i < to; i++) begin
      hrd(2'd3, v);
      chk(req, v, int'(pat(i, seed)));
    end
  endtask

  task automatic tx_bytes(input int from, input int to, input int seed);
    for (int i = from; i < to; i++) hwr(2'd3, int'(pat(i, seed)));
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual 1 expected 0");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    int v, e;
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;

    chk_st("R1 reset status", 0);

    // receive sweep over all lengths, past the depth
    for (int l = 0; l <= DEPTH + 2; l++) begin
      e = clampl(l);
      rx_open(l, l);
      hrd(2'd3, v);
      chk("R11 data read before length", v, 0);
      chk_st("R2 R11 status after start", stv(0, 0, 0, 0, 0));
      hrd(2'd2, v);
      chk(l > DEPTH ? "R6 rx clamp" : "R3 rx length", v, e);
      chk_st("R5 after latch", stv(0, 0, 1, 0, e == 0 ? 1 : 0));
      rx_bytes("R3 rx byte", 0, e, l);
      chk_st("R5 rx done", stv(e, 0, 1, 0, 1));
      hrd(2'd3, v);
      chk("R5 read after done", v, 0);
      chk_st("R5 pointer saturates", stv(e, 0, 1, 0, 1));
    end

    // transmit sweep
    for (int l = 0; l <= DEPTH + 2; l++) begin
      e = clampl(l);
      hcmd(1, 1);
      hwr(2'd3, 8'hAA);
      chk_st("R11 tx write before length", stv(0, 1, 0, 0, 0));
      hwr(2'd1, l);
      hrd(2'd1, v);
      chk(l > DEPTH ? "R6 tx clamp" : "R4 tx length", v, e);
      hwr(2'd1, 3);
      hrd(2'd1, v);
      chk("R4 second length write ignored", v, e);
      tx_bytes(0, e, 100 + l);
      hwr(2'd3, 8'h55);
      chk_st("R5 tx done", stv(e, 1, 1, 0, 1));
      chk("R5 done_o", int'(done), 1);
      chk("R4 tx_len_o", int'(tx_len), e);
      lnk_check("R4 link readback", e, 100 + l);
    end

    // receive rewind at every position
    for (int k = 0; k < 10; k++) begin
      rx_open(10, 30 + k);
      hrd(2'd2, v);
      rx_bytes("R3 rx before rewind", 0, k, 30 + k);
      hcmd(2, 0);
      chk_st("R7 rx rewind", stv(0, 0, 0, 0, 0));
      hrd(2'd3, v);
      chk("R7 R11 read after rewind", v, 0);
      hrd(2'd2, v);
      chk("R7 length refetch", v, 10);
      rx_bytes("R7 rx reread", 0, 10, 30 + k);
      chk_st("R7 rx done after reread", stv(10, 0, 1, 0, 1));
    end

    // transmit rewind at every position
    for (int k = 1; k < 10; k++) begin
      hcmd(1, 1);
      hwr(2'd1, 10);
      tx_bytes(0, k, 50);
      hcmd(2, 1);
      chk_st("R7 tx rewind", stv(0, 1, 0, 0, 0));
      hwr(2'd3, 8'h11);
      chk_st("R7 tx write ignored", stv(0, 1, 0, 0, 0));
      hwr(2'd1, 10);
      tx_bytes(0, 10, 77 + k);
      chk_st("R7 tx done", stv(10, 1, 1, 0, 1));
      lnk_check("R7 overwritten", 10, 77 + k);
    end

    // late rewind
    hcmd(2, 1);
    chk_st("R8 late rewind ignored", stv(10, 1, 1, 0, 1));
    hcmd(1, 0);
    chk_st("R2 start clears", stv(0, 0, 0, 0, 0));

    // receive pause
    rx_open(8, 9);
    hrd(2'd2, v);
    rx_bytes("R9 rx before pause", 0, 3, 9);
    hcmd(3, 0);
    chk_st("R9 paused", stv(3, 0, 1, 1, 0));
    hrd(2'd3, v);
    chk("R9 read while paused", v, 0);
    hrd(2'd2, v);
    chk_st("R9 rx held", stv(3, 0, 1, 1, 0));
    hcmd(4, 0);
    chk_st("R9 resumed", stv(3, 0, 1, 0, 0));
    rx_bytes("R9 rx resume", 3, 8, 9);
    chk_st("R9 rx done", stv(8, 0, 1, 0, 1));

    // transmit pause
    hcmd(1, 1);
    hwr(2'd1, 8);
    tx_bytes(0, 4, 61);
    hcmd(3, 1);
    hwr(2'd3, 8'h22);
    hwr(2'd1, 3);
    chk_st("R9 tx held", stv(4, 1, 1, 1, 0));
    hrd(2'd1, v);
    chk("R9 length unchanged", v, 8);
    hcmd(4, 1);
    tx_bytes(4, 8, 61);
    chk_st("R9 tx done", stv(8, 1, 1, 0, 1));
    lnk_check("R9 tx bytes", 8, 61);

    // spare codes and direction mismatch, mid receive packet
    rx_open(6, 12);
    hrd(2'd2, v);
    rx_bytes("R3 rx", 0, 2, 12);
    hcmd(0, 1);
    hcmd(5, 1);
    hcmd(6, 0);
    hcmd(7, 1);
    chk_st("R10 spare codes", stv(2, 0, 1, 0, 0));
    hwr(2'd3, 8'h33);
    chk_st("R11 wrong direction write", stv(2, 0, 1, 0, 0));
    rx_bytes("R10 rx continues", 2, 6, 12);

    // transmit side: a data read is against direction
    hcmd(1, 1);
    hwr(2'd1, 4);
    tx_bytes(0, 2, 3);
    hrd(2'd3, v);
    chk("R11 wrong direction read", v, 0);
    chk_st("R11 tx pointer held", stv(2, 1, 1, 0, 0));

    finished = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

endmodule